// File: doc/BRIEF.md
# Sector Group Protection Unit

This unit decides whether a program or erase aimed at a sector of a flash array may go ahead. Sectors are grouped in fours, and each group has one stored protect bit. An active-low write-protect input and a temporary-unprotect level sit above those bits. The write-protect input blocks every sector. The temporary-unprotect level opens every sector without touching the stored bits. The command controller reads a combinational allow flag for the sector address it presents. When it issues an access check against a denied sector, the unit answers one cycle later with a denied pulse, and the controller then finishes the operation without changing any data.

Maintenance requests go through a small state machine with four named states:
- `ST_IDLE` waits for a request.
- `ST_PROT_PULSE` times the protection pulse for one group, then sets that group's bit and returns to `ST_IDLE`.
- `ST_CLR_SWEEP` clears every group bit, one group per cycle, in ascending order, then returns to `ST_IDLE`.
- `ST_VERIFY_OUT` presents the status byte of the latched group for one cycle, then returns to `ST_IDLE`.

All transitions out of `ST_IDLE` are taken on a request. Protect and chip-unprotect requests are accepted only while the controller is not busy. The stored bits are modelled as registers.

Top module: `sect_grp_guard`

## Requirements
- R1: After reset every group is unprotected, `pu_busy` and `verify_valid` are 0, and with `wp_n`=1 every sector is allowed.
- R2: The group index is the sector address shifted right by two bits. Protecting one sector's group denies all four sectors of that group and no other sector.
- R3: While `wp_n`=0, `wr_allow` is 0 for every sector, whatever the stored bits are.
- R4: With `wp_n`=1 and `temp_unprot`=0, `wr_allow` is 1 exactly when the addressed group's bit is clear.
- R5: With `wp_n`=1 and `temp_unprot`=1, every sector is allowed. When `temp_unprot` returns to 0, every group that was protected is denied again.
- R6: When `wp_n`=0 and `temp_unprot`=1 are both asserted, write protect wins and access is denied.
- R7: A chip-unprotect request clears the bits of all groups. `pu_busy` stays 1 for exactly NUM_GROUPS cycles while it does so.
- R8: A verify request produces `verify_valid` for exactly one cycle, in the cycle after the request. `verify_data` is 8'h01 for a protected group and 8'h00 for an unprotected one. Verify is served even while `ctl_busy`=1.
- R9: A `chk_req` on a denied sector raises `deny_pulse` for exactly one cycle in the next cycle and leaves the stored bits unchanged. A `chk_req` on an allowed sector raises no pulse.
- R10: Protect and chip-unprotect requests made while `ctl_busy`=1 are ignored.
- R11: A protect request keeps `pu_busy` at 1 for exactly PULSE_CYC cycles and then the group reads as protected. Requests that arrive while `pu_busy`=1 are ignored.
- R12: When requests arrive in the same idle cycle, chip unprotect takes precedence over protect, and protect takes precedence over verify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sect_addr | input | SECT_W | Sector address of the access or request |
| chk_req | input | 1 | Access check for a program or erase |
| wp_n | input | 1 | Write protect, active low |
| temp_unprot | input | 1 | Temporary unprotect level (high-voltage detect) |
| ctl_busy | input | 1 | Command controller busy |
| prot_req | input | 1 | Protect the group of `sect_addr` |
| unprot_req | input | 1 | Chip unprotect (all groups) |
| verify_req | input | 1 | Verify the group of `sect_addr` |
| wr_allow | output | 1 | Access allowed for `sect_addr` |
| deny_pulse | output | 1 | One-cycle denial response to `chk_req` |
| verify_valid | output | 1 | `verify_data` valid |
| verify_data | output | 8 | Group status byte |
| pu_busy | output | 1 | State machine not idle |

## Verification
The hardest situation to reach is a set of simultaneous requests arriving in the single idle cycle that follows a finished sweep or pulse. The bench protects two groups, then raises chip unprotect, protect and verify in the same cycle, and checks three things: the sweep length, that no verify byte appears, and that both groups read back 00h. To check that the temporary override leaves the stored bits untouched, the bench drops the override after a run of the vector table and confirms that the protected sectors are denied again.

// File: rtl/sgg_pkg.sv
package sgg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PROT_PULSE = 2'd1,
        ST_CLR_SWEEP  = 2'd2,
        ST_VERIFY_OUT = 2'd3
    } sgg_state_e;
endpackage

// File: rtl/sgg_group_decode.sv
module sgg_group_decode #(
    parameter int SECT_W    = 6,
    parameter int GRP_SHIFT = 2,
    localparam int GRP_W    = SECT_W - GRP_SHIFT
) (
    input  logic [SECT_W-1:0] sect,
    output logic [GRP_W-1:0]  grp
);
    // Four adjacent sectors share one group: drop the low address bits.
    assign grp = sect[SECT_W-1:GRP_SHIFT];
endmodule

// File: rtl/sgg_protect_store.sv
module sgg_protect_store #(
    parameter int GRP_W      = 4,
    localparam int NUM_GROUPS = 1 << GRP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [GRP_W-1:0]      set_idx,
    input  logic                  clr_en,
    input  logic [GRP_W-1:0]      clr_idx,
    output logic [NUM_GROUPS-1:0] prot_bits
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prot_bits[g] <= 1'b0;
            end else if (clr_en && clr_idx == GRP_W'(g)) begin
                prot_bits[g] <= 1'b0;
            end else if (set_en && set_idx == GRP_W'(g)) begin
                prot_bits[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sgg_access_gate.sv
module sgg_access_gate #(
    parameter int GRP_W      = 4,
    localparam int NUM_GROUPS = 1 << GRP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] prot_bits,
    input  logic [GRP_W-1:0]      grp,
    input  logic                  wp_n,
    input  logic                  temp_unprot,
    input  logic                  chk_req,
    output logic                  wr_allow,
    output logic                  deny_pulse
);
    logic group_open;

    // Write protect overrides everything; temporary unprotect overrides stored bits.
    always_comb begin
        group_open = temp_unprot || !prot_bits[grp];
        wr_allow   = wp_n && group_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deny_pulse <= 1'b0;
        end else begin
            deny_pulse <= chk_req && !wr_allow;
        end
    end
endmodule

// File: rtl/sgg_ctrl.sv
module sgg_ctrl
    import sgg_pkg::*;
#(
    parameter int GRP_W      = 4,
    parameter int PULSE_CYC  = 4,
    localparam int NUM_GROUPS = 1 << GRP_W,
    localparam int CNT_W      = $clog2(PULSE_CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_busy,
    input  logic                  prot_req,
    input  logic                  unprot_req,
    input  logic                  verify_req,
    input  logic [GRP_W-1:0]      req_grp,
    input  logic [NUM_GROUPS-1:0] prot_bits,
    output logic                  set_en,
    output logic [GRP_W-1:0]      set_idx,
    output logic                  clr_en,
    output logic [GRP_W-1:0]      clr_idx,
    output logic                  verify_valid,
    output logic [7:0]            verify_data,
    output logic                  pu_busy
);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_GROUPS - 1);

    sgg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [GRP_W-1:0] grp_q;
    logic             accept_maint;

    assign accept_maint = !ctl_busy;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_maint && unprot_req) begin
                    state_d = ST_CLR_SWEEP;
                end else if (accept_maint && prot_req) begin
                    state_d = ST_PROT_PULSE;
                end else if (verify_req) begin
                    state_d = ST_VERIFY_OUT;
                end
            end
            ST_PROT_PULSE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
            end
            ST_CLR_SWEEP: begin
                if (grp_q == GRP_LAST) state_d = ST_IDLE;
            end
            ST_VERIFY_OUT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (state_d == ST_PROT_PULSE) begin
                        cnt_q <= CNT_LOAD;
                        grp_q <= req_grp;
                    end else if (state_d == ST_CLR_SWEEP) begin
                        grp_q <= '0;
                    end else if (state_d == ST_VERIFY_OUT) begin
                        grp_q <= req_grp;
                    end
                end
                ST_PROT_PULSE: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end
                ST_CLR_SWEEP: begin
                    grp_q <= grp_q + 1'b1;
                end
                ST_VERIFY_OUT: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        set_en       = 1'b0;
        clr_en       = 1'b0;
        verify_valid = 1'b0;
        verify_data  = 8'h00;
        set_idx      = grp_q;
        clr_idx      = grp_q;
        pu_busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:       pu_busy = 1'b0;
            ST_PROT_PULSE: set_en  = (cnt_q == '0);
            ST_CLR_SWEEP:  clr_en  = 1'b1;
            ST_VERIFY_OUT: begin
                verify_valid = 1'b1;
                verify_data  = {7'b0, prot_bits[grp_q]};
            end
            default: pu_busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/sect_grp_guard.sv
module sect_grp_guard #(
    parameter int SECT_W    = 6,
    parameter int GRP_SHIFT = 2,
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SECT_W-1:0] sect_addr,
    input  logic              chk_req,
    input  logic              wp_n,
    input  logic              temp_unprot,
    input  logic              ctl_busy,
    input  logic              prot_req,
    input  logic              unprot_req,
    input  logic              verify_req,
    output logic              wr_allow,
    output logic              deny_pulse,
    output logic              verify_valid,
    output logic [7:0]        verify_data,
    output logic              pu_busy
);
    localparam int GRP_W      = SECT_W - GRP_SHIFT;
    localparam int NUM_GROUPS = 1 << GRP_W;

    logic [GRP_W-1:0]      grp;
    logic [NUM_GROUPS-1:0] prot_bits;
    logic                  set_en, clr_en;
    logic [GRP_W-1:0]      set_idx, clr_idx;

    sgg_group_decode #(.SECT_W(SECT_W), .GRP_SHIFT(GRP_SHIFT)) u_dec (
        .sect (sect_addr),
        .grp  (grp)
    );

    sgg_protect_store #(.GRP_W(GRP_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .set_idx   (set_idx),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .prot_bits (prot_bits)
    );

    sgg_access_gate #(.GRP_W(GRP_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_bits   (prot_bits),
        .grp         (grp),
        .wp_n        (wp_n),
        .temp_unprot (temp_unprot),
        .chk_req     (chk_req),
        .wr_allow    (wr_allow),
        .deny_pulse  (deny_pulse)
    );

    sgg_ctrl #(.GRP_W(GRP_W), .PULSE_CYC(PULSE_CYC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_busy     (ctl_busy),
        .prot_req     (prot_req),
        .unprot_req   (unprot_req),
        .verify_req   (verify_req),
        .req_grp      (grp),
        .prot_bits    (prot_bits),
        .set_en       (set_en),
        .set_idx      (set_idx),
        .clr_en       (clr_en),
        .clr_idx      (clr_idx),
        .verify_valid (verify_valid),
        .verify_data  (verify_data),
        .pu_busy      (pu_busy)
    );
endmodule

// File: rtl/sect_grp_guard_chk.sv
module sect_grp_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chk_req,
    input logic       wp_n,
    input logic       temp_unprot,
    input logic       ctl_busy,
    input logic       prot_req,
    input logic       unprot_req,
    input logic       verify_req,
    input logic       wr_allow,
    input logic       deny_pulse,
    input logic       verify_valid,
    input logic [7:0] verify_data,
    input logic       pu_busy
);
    AST_WP_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |-> !wr_allow); // R3

    AST_TEMP_OPENS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_n && temp_unprot) |-> wr_allow); // R5

    AST_WP_OVER_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && temp_unprot) |-> !wr_allow); // R6

    AST_DENY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && !wr_allow) |=> deny_pulse); // R9

    AST_DENY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        deny_pulse |-> $past(chk_req && !wr_allow)); // R9

    AST_VERIFY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        verify_valid |-> (verify_data[7:1] == 7'd0)); // R8

    AST_VERIFY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        verify_valid |=> !verify_valid); // R8

    AST_BUSY_IGNORES_MAINT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && !pu_busy && !verify_req && (prot_req || unprot_req)) |=> !pu_busy); // R10

    AST_IDLE_VERIFY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_busy |-> !verify_valid); // R8
endmodule

bind sect_grp_guard sect_grp_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_req      (chk_req),
    .wp_n         (wp_n),
    .temp_unprot  (temp_unprot),
    .ctl_busy     (ctl_busy),
    .prot_req     (prot_req),
    .unprot_req   (unprot_req),
    .verify_req   (verify_req),
    .wr_allow     (wr_allow),
    .deny_pulse   (deny_pulse),
    .verify_valid (verify_valid),
    .verify_data  (verify_data),
    .pu_busy      (pu_busy)
);

// File: tb/sect_grp_guard_tb_top.sv
module sect_grp_guard_tb_top;
    localparam int SECT_W     = 6;
    localparam int PULSE_CYC  = 4;
    localparam int NUM_GROUPS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SECT_W-1:0] sect_addr = '0;
    logic chk_req = 1'b0, wp_n = 1'b1, temp_unprot = 1'b0, ctl_busy = 1'b0;
    logic prot_req = 1'b0, unprot_req = 1'b0, verify_req = 1'b0;
    logic wr_allow, deny_pulse, verify_valid, pu_busy;
    logic [7:0] verify_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sect_grp_guard #(.SECT_W(SECT_W), .GRP_SHIFT(2), .PULSE_CYC(PULSE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sect_addr(sect_addr), .chk_req(chk_req),
        .wp_n(wp_n), .temp_unprot(temp_unprot), .ctl_busy(ctl_busy),
        .prot_req(prot_req), .unprot_req(unprot_req), .verify_req(verify_req),
        .wr_allow(wr_allow), .deny_pulse(deny_pulse), .verify_valid(verify_valid),
        .verify_data(verify_data), .pu_busy(pu_busy)
    );

    // Vector: [8] wp_n, [7] temp_unprot, [6:1] sector, [0] expected wr_allow.
    // Valid with groups 1 (sectors 4..7) and 3 (sectors 12..15) protected.
    localparam logic [8:0] VEC [0:13] = '{
        {1'b1, 1'b0, 6'd4,  1'b0},  // R2 first sector of group 1
        {1'b1, 1'b0, 6'd7,  1'b0},  // R2 last sector of group 1
        {1'b1, 1'b0, 6'd3,  1'b1},  // R2 neighbour below
        {1'b1, 1'b0, 6'd8,  1'b1},  // R2 neighbour above
        {1'b1, 1'b0, 6'd12, 1'b0},  // R4
        {1'b1, 1'b0, 6'd15, 1'b0},  // R4
        {1'b1, 1'b0, 6'd16, 1'b1},  // R4
        {1'b1, 1'b0, 6'd63, 1'b1},  // R4
        {1'b0, 1'b0, 6'd3,  1'b0},  // R3
        {1'b0, 1'b0, 6'd63, 1'b0},  // R3
        {1'b1, 1'b1, 6'd5,  1'b1},  // R5
        {1'b1, 1'b1, 6'd13, 1'b1},  // R5
        {1'b0, 1'b1, 6'd5,  1'b0},  // R6
        {1'b0, 1'b1, 6'd8,  1'b0}   // R6
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (pu_busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_protect(input logic [SECT_W-1:0] s, output int n);
        @(negedge clk);
        sect_addr = s; prot_req = 1'b1;
        @(negedge clk);
        prot_req = 1'b0;
        wait_idle(n);
    endtask

    task automatic do_verify(input logic [SECT_W-1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sect_addr = s; verify_req = 1'b1;
        @(negedge clk);
        verify_req = 1'b0;
        check({tag, " valid"}, {7'b0, verify_valid}, 8'h01);
        check({tag, " data"}, verify_data, exp);
        @(negedge clk);
        check({tag, " single"}, {7'b0, verify_valid}, 8'h00);
    endtask

    initial begin
        int n;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {7'b0, pu_busy}, 8'h00);
        check("R1 verify_valid", {7'b0, verify_valid}, 8'h00);
        for (int s = 0; s < 64; s += 9) begin
            sect_addr = SECT_W'(s); #1;
            check("R1 allow", {7'b0, wr_allow}, 8'h01);
        end
        do_verify(6'd20, 8'h00, "R1 verify");

        // R11 protect pulse length, groups 1 and 3
        do_protect(6'd5, n);
        check("R11 pulse length", 8'(n), 8'(PULSE_CYC));
        do_protect(6'd14, n);
        check("R11 pulse length", 8'(n), 8'(PULSE_CYC));
        do_verify(6'd6, 8'h01, "R8 protected");
        do_verify(6'd9, 8'h00, "R8 unprotected");

        // Vector table
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            wp_n = VEC[i][8]; temp_unprot = VEC[i][7]; sect_addr = VEC[i][6:1];
            #1;
            if (!VEC[i][8] && VEC[i][7]) tag = "R6";
            else if (!VEC[i][8])         tag = "R3";
            else if (VEC[i][7])          tag = "R5";
            else                         tag = "R2/R4";
            check({tag, " vector allow"}, {7'b0, wr_allow}, {7'b0, VEC[i][0]});
        end
        // R5: override released, protection returns
        @(negedge clk);
        wp_n = 1'b1; temp_unprot = 1'b0; sect_addr = 6'd5; #1;
        check("R5 reprotected", {7'b0, wr_allow}, 8'h00);
        sect_addr = 6'd13; #1;
        check("R5 reprotected", {7'b0, wr_allow}, 8'h00);

        // R9 denied check
        @(negedge clk);
        sect_addr = 6'd6; chk_req = 1'b1;
        @(negedge clk);
        chk_req = 1'b0;
        check("R9 deny pulse", {7'b0, deny_pulse}, 8'h01);
        @(negedge clk);
        check("R9 one cycle", {7'b0, deny_pulse}, 8'h00);
        do_verify(6'd6, 8'h01, "R9 bits kept");
        // R9 allowed check: no pulse
        @(negedge clk);
        sect_addr = 6'd30; chk_req = 1'b1;
        @(negedge clk);
        chk_req = 1'b0;
        check("R9 no pulse", {7'b0, deny_pulse}, 8'h00);

        // R10 maintenance ignored while controller busy
        @(negedge clk);
        ctl_busy = 1'b1; sect_addr = 6'd40; prot_req = 1'b1;
        @(negedge clk);
        prot_req = 1'b0;
        check("R10 protect ignored busy", {7'b0, pu_busy}, 8'h00);
        unprot_req = 1'b1;
        @(negedge clk);
        unprot_req = 1'b0;
        check("R10 unprotect ignored busy", {7'b0, pu_busy}, 8'h00);
        do_verify(6'd40, 8'h00, "R10 R8 verify under busy");
        do_verify(6'd4, 8'h01, "R10 bits kept");
        ctl_busy = 1'b0;

        // R11 request during pulse ignored
        @(negedge clk);
        sect_addr = 6'd48; prot_req = 1'b1;
        @(negedge clk);
        sect_addr = 6'd52;
        @(negedge clk);
        prot_req = 1'b0;
        wait_idle(n);
        do_verify(6'd48, 8'h01, "R11 first accepted");
        do_verify(6'd52, 8'h00, "R11 second ignored");

        // R12 + R7: all three requests together
        @(negedge clk);
        sect_addr = 6'd24; unprot_req = 1'b1; prot_req = 1'b1; verify_req = 1'b1;
        @(negedge clk);
        unprot_req = 1'b0; prot_req = 1'b0; verify_req = 1'b0;
        check("R12 no verify", {7'b0, verify_valid}, 8'h00);
        wait_idle(n);
        check("R7 sweep length", 8'(n), 8'(NUM_GROUPS));
        do_verify(6'd5, 8'h00, "R7 group1 cleared");
        do_verify(6'd13, 8'h00, "R7 group3 cleared");
        do_verify(6'd24, 8'h00, "R12 protect lost");
        sect_addr = 6'd50; #1;
        check("R7 allow after clear", {7'b0, wr_allow}, 8'h01);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule